// File: doc/BRIEF.md
# Expansion Bus Master Arbitration Sequencer

This block sits on the master side of a shared parallel expansion bus. An external arbiter owns the bus and talks to the master through an active-low request and grant pair. Transfer commands arrive from an internal queue on a valid/ready handshake. For each command the sequencer lowers request and waits for grant. Once it holds the bus, it walks the transfer through five timing phases: address setup, address hold, data strobe, recovery and end. The length of each phase is set by its own configuration field.

Request stays low for the whole transfer. When the next command is already waiting as a transfer finishes, the sequencer chains straight into it without giving up the bus. The arbiter may leave grant parked on this master. A new request then still has to be held for two cycles before the first phase begins, so the arbiter cannot take grant away in the same cycle that request appears. After each release the sequencer leaves the arbiter room: it waits for grant to go away, or for one idle cycle, before it asks again. Grant that disappears in the middle of a transfer breaks the protocol, and the sequencer records it in a sticky error flag.

Top module: `exp_arb_seq`

## Requirements
- R1: `req_n` is low in every cycle from the cycle after a command is accepted up to and including the last cycle of that transfer's final phase. It is high in the cycle after the final phase when no further command was accepted.
- R2: While `phase` is 1 (request wait) and `gnt_n` is high, the sequencer stays in request wait. The first timing phase begins only in the cycle after a cycle in which `gnt_n` was sampled low.
- R3: After acceptance, `phase` shows request wait (1) for at least two cycles. With grant parked low, the first timing phase appears in the third cycle of request being low.
- R4: `phase` encodes 0 idle, 1 request wait, 2 address setup, 3 address hold, 4 data strobe, 5 recovery, 6 end. The timing phases run in the order 2, 3, 4, 5, 6, and each lasts as many cycles as its 4-bit field (`cfg_setup`, `cfg_hold`, `cfg_strobe`, `cfg_recov`, `cfg_end`).
- R5: A setup, hold, recovery or end field of zero skips that phase entirely. A strobe field of zero still gives one strobe cycle. Strobe lengths of 3 or more work together with end lengths of 0, 1 and 2.
- R6: `done` is high for exactly the last cycle of a transfer's final phase. `xfer_addr` shows the accepted command's address throughout its phases.
- R7: `cmd_ready` is high only in idle, subject to R9, or in the last cycle of a transfer. It is low during request wait.
- R8: A command accepted in the last cycle of a transfer starts its first timing phase in the very next cycle. It skips request wait and keeps `req_n` low.
- R9: In the first idle cycle after request is released, `cmd_ready` follows grant: high only if `gnt_n` is high. In every later idle cycle it is high.
- R10: If `gnt_n` is high in any cycle of a timing phase (2 to 6), `gnt_err` goes high in the next cycle and stays high until reset.
- R11: A synchronous active-high `rst` returns the sequencer to idle with `req_n` high, `done` low and `gnt_err` low, even mid-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_setup | input | 4 | Address setup phase length in cycles |
| cfg_hold | input | 4 | Address hold phase length in cycles |
| cfg_strobe | input | 4 | Data strobe phase length (zero acts as one) |
| cfg_recov | input | 4 | Recovery phase length in cycles |
| cfg_end | input | 4 | End phase length in cycles |
| cmd_valid | input | 1 | Command pending from the queue |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_addr | input | ADDR_W | Command address |
| req_n | output | 1 | Active-low bus request to the arbiter |
| gnt_n | input | 1 | Active-low bus grant from the arbiter |
| phase | output | 3 | Current sequencer phase code |
| xfer_addr | output | ADDR_W | Address of the transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| gnt_err | output | 1 | Sticky flag for grant lost mid-transfer |

## Verification
The bench uses the default build: a 16-bit address, the two-cycle park window and 4-bit phase fields. With these settings the exact third-cycle start under a parked grant can be checked cycle by cycle. The same applies to skipping each zero-length phase and to the one-cycle minimum strobe. Small field values keep every phase boundary short enough to walk through with directed checks. Grant is both parked and delayed, and it is also dropped at release. Together these cover both sides of the post-release rule and the request-wait hold.

// File: rtl/exp_arb_pkg.sv
package exp_arb_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_REQ    = 3'd1,
        PH_SETUP  = 3'd2,
        PH_HOLD   = 3'd3,
        PH_STROBE = 3'd4,
        PH_RECOV  = 3'd5,
        PH_END    = 3'd6
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] setup;
        logic [LEN_W-1:0] hold;
        logic [LEN_W-1:0] strobe;
        logic [LEN_W-1:0] recov;
        logic [LEN_W-1:0] fin;
    } timing_t;

    // Cycle count of a timing phase; strobe never collapses below one cycle.
    function automatic logic [LEN_W-1:0] phase_len(phase_e p, timing_t t);
        case (p)
            PH_SETUP:  return t.setup;
            PH_HOLD:   return t.hold;
            PH_STROBE: return (t.strobe == '0) ? LEN_W'(1) : t.strobe;
            PH_RECOV:  return t.recov;
            PH_END:    return t.fin;
            default:   return '0;
        endcase
    endfunction

    // Raw successor in the fixed phase order.
    function automatic phase_e phase_step(phase_e p);
        case (p)
            PH_REQ:    return PH_SETUP;
            PH_SETUP:  return PH_HOLD;
            PH_HOLD:   return PH_STROBE;
            PH_STROBE: return PH_RECOV;
            PH_RECOV:  return PH_END;
            default:   return PH_IDLE;
        endcase
    endfunction

    // Next phase with a non-zero length, or PH_IDLE when the transfer ends.
    function automatic phase_e phase_after(phase_e p, timing_t t);
        phase_e c;
        c = p;
        for (int i = 0; i < 5; i++) begin
            c = phase_step(c);
            if (c == PH_IDLE) return PH_IDLE;
            if (phase_len(c, t) != '0) return c;
        end
        return PH_IDLE;
    endfunction

endpackage

// File: rtl/exp_arb_timer.sv
module exp_arb_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/exp_arb_req_gate.sv
module exp_arb_req_gate #(
    parameter int PARK_WAIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_req,
    input  logic release_bus,
    input  logic in_idle,
    input  logic gnt_n,
    output logic park_ok,
    output logic may_req
);
    localparam int CW = (PARK_WAIT > 1) ? $clog2(PARK_WAIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(PARK_WAIT - 1);

    logic [CW-1:0] wait_q;
    logic          rel_recent_q;

    // Counts request-wait cycles so a parked grant is not used too early.
    always_ff @(posedge clk) begin
        if (rst || !in_req)     wait_q <= '0;
        else if (wait_q != LAST) wait_q <= wait_q + 1'b1;
    end

    // Remembers a release until one idle cycle has passed.
    always_ff @(posedge clk) begin
        if (rst)              rel_recent_q <= 1'b0;
        else if (release_bus) rel_recent_q <= 1'b1;
        else if (in_idle)     rel_recent_q <= 1'b0;
    end

    assign park_ok = (wait_q == LAST);
    assign may_req = !rel_recent_q || gnt_n;
endmodule

// File: rtl/exp_arb_seq.sv
module exp_arb_seq
    import exp_arb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PARK_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  cfg_setup,
    input  logic [LEN_W-1:0]  cfg_hold,
    input  logic [LEN_W-1:0]  cfg_strobe,
    input  logic [LEN_W-1:0]  cfg_recov,
    input  logic [LEN_W-1:0]  cfg_end,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              req_n,
    input  logic              gnt_n,
    output logic [2:0]        phase,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              done,
    output logic              gnt_err
);
    timing_t          tm;
    phase_e           ph_q, ph_d, nxt_in, first_ph;
    logic             tmr_zero, tmr_load, accept;
    logic [LEN_W-1:0] tmr_val;
    logic             in_xfer, last_cyc, release_bus;
    logic             park_ok, may_req;
    logic [ADDR_W-1:0] addr_q;
    logic             err_q;

    assign tm = '{setup: cfg_setup, hold: cfg_hold, strobe: cfg_strobe,
                  recov: cfg_recov, fin: cfg_end};

    assign in_xfer     = ph_q inside {PH_SETUP, PH_HOLD, PH_STROBE, PH_RECOV, PH_END};
    assign nxt_in      = phase_after(ph_q, tm);
    assign first_ph    = phase_after(PH_REQ, tm);
    assign last_cyc    = in_xfer && tmr_zero && (nxt_in == PH_IDLE);
    assign release_bus = last_cyc && !cmd_valid;

    exp_arb_timer #(.W(LEN_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    exp_arb_req_gate #(.PARK_WAIT(PARK_WAIT)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .in_req      (ph_q == PH_REQ),
        .release_bus (release_bus),
        .in_idle     (ph_q == PH_IDLE),
        .gnt_n       (gnt_n),
        .park_ok     (park_ok),
        .may_req     (may_req)
    );

    always_comb begin
        ph_d     = ph_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (cmd_valid && may_req) begin
                    ph_d   = PH_REQ;
                    accept = 1'b1;
                end
            end
            PH_REQ: begin
                if (park_ok && !gnt_n) begin
                    ph_d     = first_ph;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(first_ph, tm) - 1'b1;
                end
            end
            default: begin
                if (tmr_zero) begin
                    if (nxt_in != PH_IDLE) begin
                        ph_d     = nxt_in;
                        tmr_load = 1'b1;
                        tmr_val  = phase_len(nxt_in, tm) - 1'b1;
                    end else if (cmd_valid) begin
                        ph_d     = first_ph;
                        tmr_load = 1'b1;
                        tmr_val  = phase_len(first_ph, tm) - 1'b1;
                        accept   = 1'b1;
                    end else begin
                        ph_d = PH_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (accept)            addr_q <= cmd_addr;
            if (in_xfer && gnt_n)  err_q  <= 1'b1;
        end
    end

    assign req_n     = (ph_q == PH_IDLE);
    assign cmd_ready = ((ph_q == PH_IDLE) && may_req) || last_cyc;
    assign done      = last_cyc;
    assign phase     = ph_q;
    assign xfer_addr = addr_q;
    assign gnt_err   = err_q;
endmodule

// File: rtl/exp_arb_seq_chk.sv
module exp_arb_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       req_n,
    input logic       gnt_n,
    input logic [2:0] phase,
    input logic       done,
    input logic       gnt_err
);
    // R1: bus stays requested through every timing phase
    a_r1_req_held: assert property (@(posedge clk) disable iff (rst)
        (phase >= 3'd2 && phase <= 3'd6) |-> !req_n);

    // R2: no progress out of request wait without grant
    a_r2_wait_grant: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1 && gnt_n) |=> (phase == 3'd1));

    // R3: two request-wait cycles precede the first timing phase
    a_r3_park_wait: assert property (@(posedge clk) disable iff (rst)
        (phase >= 3'd2 && $past(phase) == 3'd1) |-> ($past(phase, 2) == 3'd1));

    // R7: ready only in idle or at the close of a transfer
    a_r7_ready_scope: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (phase == 3'd0 || done));

    // R8: chained command keeps the bus and enters a timing phase
    a_r8_chain: assert property (@(posedge clk) disable iff (rst)
        (done && cmd_valid) |=> (phase >= 3'd2 && !req_n));

    // R10: grant error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        gnt_err |=> gnt_err);
endmodule

bind exp_arb_seq exp_arb_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .req_n     (req_n),
    .gnt_n     (gnt_n),
    .phase     (phase),
    .done      (done),
    .gnt_err   (gnt_err)
);

// File: tb/sim_exp_arb_seq.sv
module sim_exp_arb_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  cfg_setup, cfg_hold, cfg_strobe, cfg_recov, cfg_end;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [15:0] cmd_addr;
    logic        req_n;
    logic        gnt_n;
    logic [2:0]  phase;
    logic [15:0] xfer_addr;
    logic        done;
    logic        gnt_err;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    exp_arb_seq u0 (
        .clk(clk), .rst(rst),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_strobe(cfg_strobe),
        .cfg_recov(cfg_recov), .cfg_end(cfg_end),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .req_n(req_n), .gnt_n(gnt_n), .phase(phase), .xfer_addr(xfer_addr),
        .done(done), .gnt_err(gnt_err)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input int s, input int h, input int st, input int r, input int e);
        cfg_setup = 4'(s); cfg_hold = 4'(h); cfg_strobe = 4'(st);
        cfg_recov = 4'(r); cfg_end = 4'(e);
    endtask

    // Expected phase codes per cycle, from R4/R5.
    task automatic build_seq(input int s, input int h, input int st, input int r, input int e);
        exp_q.delete();
        repeat (s) exp_q.push_back(2);
        repeat (h) exp_q.push_back(3);
        repeat ((st == 0) ? 1 : st) exp_q.push_back(4);
        repeat (r) exp_q.push_back(5);
        repeat (e) exp_q.push_back(6);
    endtask

    task automatic run_xfer(input int s, input int h, input int st, input int r, input int e,
                            input int addr, input int gdelay, input bit drop_gnt);
        set_cfg(s, h, st, r, e);
        build_seq(s, h, st, r, e);
        if (gdelay > 0) gnt_n = 1'b1;
        cmd_addr  = 16'(addr);
        cmd_valid = 1'b1;
        #1;
        chk_eq("R7 ready in idle", cmd_ready, 1);
        tick;
        cmd_valid = 1'b0;
        for (int k = 0; k < 2 + gdelay; k++) begin
            chk_eq((k < 2) ? "R3 park wait" : "R2 wait for grant", phase, 1);
            chk_eq("R1 request low in wait", req_n, 0);
            chk_eq("R7 no ready in wait", cmd_ready, 0);
            if (k == 2 + gdelay - 1) gnt_n = 1'b0;
            tick;
        end
        for (int i = 0; i < exp_q.size(); i++) begin
            chk_eq("R4 phase order", phase, exp_q[i]);
            chk_eq("R1 request held", req_n, 0);
            chk_eq("R6 done pulse", done, (i == exp_q.size() - 1) ? 1 : 0);
            chk_eq("R6 address", xfer_addr, addr);
            chk_eq("R10 no error", gnt_err, 0);
            tick;
        end
        chk_eq("R1 request released", req_n, 1);
        chk_eq("R4 idle after end", phase, 0);
        chk_eq("R6 done low after", done, 0);
        if (drop_gnt) begin
            gnt_n = 1'b1;
            #1;
            chk_eq("R9 ready with grant gone", cmd_ready, 1);
        end else begin
            chk_eq("R9 ready blocked first idle", cmd_ready, 0);
        end
        tick;
        chk_eq("R9 ready after idle cycle", cmd_ready, 1);
        gnt_n = 1'b0;
    endtask

    task automatic t_reset;
        chk_eq("R11 reset phase", phase, 0);
        chk_eq("R11 reset req_n", req_n, 1);
        chk_eq("R11 reset done", done, 0);
        chk_eq("R11 reset err", gnt_err, 0);
    endtask

    task automatic t_chain;
        set_cfg(0, 1, 2, 0, 1);
        build_seq(0, 1, 2, 0, 1);
        gnt_n     = 1'b0;
        cmd_addr  = 16'h1111;
        cmd_valid = 1'b1;
        #1;
        chk_eq("R7 ready chain start", cmd_ready, 1);
        tick;
        cmd_addr = 16'h2222;
        chk_eq("R7 ready low in wait", cmd_ready, 0);
        tick;
        tick;
        for (int i = 0; i < exp_q.size(); i++) begin
            chk_eq("R8 first phase order", phase, exp_q[i]);
            chk_eq("R8 first address", xfer_addr, 16'h1111);
            if (i == exp_q.size() - 1) begin
                chk_eq("R8 done at chain", done, 1);
                chk_eq("R7 ready at last cycle", cmd_ready, 1);
            end
            tick;
        end
        cmd_valid = 1'b0;
        for (int i = 0; i < exp_q.size(); i++) begin
            chk_eq("R8 second phase order", phase, exp_q[i]);
            chk_eq("R8 bus kept", req_n, 0);
            chk_eq("R8 second address", xfer_addr, 16'h2222);
            tick;
        end
        chk_eq("R1 release after chain", req_n, 1);
        tick;
    endtask

    task automatic t_gnt_loss;
        set_cfg(0, 0, 3, 0, 0);
        gnt_n     = 1'b0;
        cmd_addr  = 16'h0BAD;
        cmd_valid = 1'b1;
        tick;
        cmd_valid = 1'b0;
        tick;
        tick;
        chk_eq("R5 strobe entered", phase, 4);
        gnt_n = 1'b1;
        tick;
        chk_eq("R10 error raised", gnt_err, 1);
        gnt_n = 1'b0;
        tick;
        tick;
        chk_eq("R10 error held in idle", gnt_err, 1);
        rst = 1'b1;
        tick;
        rst = 1'b0;
        chk_eq("R11 error cleared", gnt_err, 0);
        tick;
    endtask

    task automatic t_reset_mid;
        set_cfg(3, 3, 9, 3, 2);
        gnt_n     = 1'b0;
        cmd_addr  = 16'h7777;
        cmd_valid = 1'b1;
        tick;
        cmd_valid = 1'b0;
        repeat (5) tick;
        chk_eq("R11 busy before reset", req_n, 0);
        rst = 1'b1;
        tick;
        chk_eq("R11 mid reset phase", phase, 0);
        chk_eq("R11 mid reset req_n", req_n, 1);
        chk_eq("R11 mid reset done", done, 0);
        rst = 1'b0;
        tick;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        set_cfg(0, 0, 0, 0, 0);
        cmd_valid = 1'b0;
        cmd_addr  = '0;
        gnt_n     = 1'b1;
        repeat (3) tick;
        t_reset();
        rst   = 1'b0;
        gnt_n = 1'b0;
        tick;
        run_xfer(1, 2, 3, 1, 2, 16'hA5A5, 0, 1'b0);   // R4 all phases, parked
        run_xfer(0, 0, 0, 0, 0, 16'h0042, 0, 1'b0);   // R5 all zero
        run_xfer(0, 0, 3, 0, 0, 16'h1234, 0, 1'b1);   // R5 end 0, R9 grant gone
        run_xfer(2, 0, 3, 1, 1, 16'h4321, 0, 1'b0);   // R5 end 1
        run_xfer(1, 0, 4, 0, 2, 16'hFFFF, 3, 1'b0);   // R2 delayed grant
        t_chain();
        t_gnt_loss();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule